// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on the local side of a local-bus to VME bridge and decides where an outgoing request lands. Eight windows are programmed through a 32-bit write port. Each window holds a lower bound, an upper bound, a translation offset and an attribute word. For every request it searches all windows in parallel. It returns whether any enabled window covers the address, which window was chosen, the VME address after translation, and the bus attributes of that window: address space code, transfer protocol code, data width, privilege level and program/data marking.

Window bounds work in 64 KiB granules. A window covers every granule from its lower-bound granule up to its upper-bound granule, and both of those granules are included. When windows overlap, the lowest-numbered one is chosen. The result is captured in a register and appears exactly one clock after the request.

Top module: `ob_window_unit`

## Requirements
- R1: After reset all windows are disabled. A request then produces a response with rspHit low, rspWin zero, rspAddr zero and every attribute output zero. rspValid is low until the first request.
- R2: Window w is configured at byte address 0x100 + 0x20*w, and each window uses eight words. Offset 0x00 is the lower bound upper half and 0x04 its lower half. Offset 0x08 is the upper bound upper half and 0x0C its lower half. Offset 0x10 is the translation offset upper half and 0x14 its lower half. Offset 0x1C is the attribute word. A write to offset 0x18 is accepted with no effect. Writes outside 0x100..0x1FF, and writes whose address has bits 1:0 not zero, have no effect.
- R3: Attribute bit 31 enables a window. A window with bit 31 clear never produces a hit, whatever its bounds are.
- R4: Bits 15:0 of the bound words are ignored. A window hits when reqAddr[63:16] is at least the lower-bound granule and at most the upper-bound granule.
- R5: On a hit, rspAddr equals reqAddr plus the window's 64-bit offset, with offset bits 15:0 taken as zero. rspAddr[15:0] therefore always equals reqAddr[15:0]. The addition wraps modulo 2^64.
- R6: When several enabled windows contain the address, the window with the lowest index is reported.
- R7: When no enabled window contains the address, rspHit is low and rspWin, rspAddr and all attribute outputs are zero.
- R8: On a hit, the attribute outputs come from the chosen window's attribute word. rspAddrMode = bits 3:0 (0 A16, 1 A24, 2 A32, 4 A64, 5 CSR, 8..0xB user). rspXferMode = bits 10:8 (0 single, 1 block, 2 multiplexed block, 3 two-edge, 4 two-edge source-synchronous, 5 its broadcast form). rspWidth = bits 7:6 (0 16-bit, 1 32-bit). rspSuper = bit 5. rspProgram = bit 4.
- R9: A request sampled with reqValid at one rising edge produces rspValid high for exactly the following cycle, and back-to-back requests are supported. A configuration write at the same edge as a request does not affect that request; it affects the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | CFG_AW (12) | Configuration byte address |
| cfgWrData | input | 32 | Configuration write data |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 64 | Local request address |
| rspValid | output | 1 | Result valid, one cycle after a request |
| rspHit | output | 1 | An enabled window contained the address |
| rspWin | output | 3 | Index of the chosen window |
| rspAddr | output | 64 | Translated VME address |
| rspAddrMode | output | 4 | Address space code of the chosen window |
| rspXferMode | output | 3 | Transfer protocol code |
| rspWidth | output | 2 | Data width code |
| rspSuper | output | 1 | Supervisor access marking |
| rspProgram | output | 1 | Program access marking |

## Verification
The assertions check four things on every cycle: the one-cycle request-to-response timing, that no response appears without a request, that a miss reports all-zero address and attributes, and that the low 16 address bits pass through unchanged on a hit. Bound inclusivity at both ends, lowest-index priority among overlapping windows, enable gating, offset arithmetic with 64-bit wrap, the ignored register slots and the same-edge write/request ordering depend on programmed window contents. Only the bench scenarios, compared against its own shadow model, show these.

// File: rtl/ob_window_pkg.sv
package ob_window_pkg;
  localparam int NUM_WIN_DEF = 8;
  localparam int WIN_IDX_W   = 3;
  localparam int CFG_AW_DEF  = 12;
  localparam int WIN_BASE    = 'h100;
  localparam int STRIDE_LG   = 5;
  localparam int ADDR_W      = 64;
  localparam int GRAN_LG     = 16;
  localparam int GRAN_W      = ADDR_W - GRAN_LG;
  localparam int HALF_W      = 32;

  typedef enum logic [2:0] {
    FLD_LO_HI   = 3'd0,
    FLD_LO_LO   = 3'd1,
    FLD_HI_HI   = 3'd2,
    FLD_HI_LO   = 3'd3,
    FLD_OFF_HI  = 3'd4,
    FLD_OFF_LO  = 3'd5,
    FLD_SPARE   = 3'd6,
    FLD_ATTR    = 3'd7
  } winField_e;

  typedef struct packed {
    logic       en;
    logic [2:0] xfer;
    logic [1:0] width;
    logic       sup;
    logic       pgm;
    logic [3:0] space;
  } winAttr_t;

  typedef struct packed {
    logic                 wrEn;
    logic [WIN_IDX_W-1:0] wrWin;
    winField_e            wrField;
    logic [HALF_W-1:0]    wrData;
    logic                 capture;
  } winStrobe_t;

  function automatic winAttr_t unpackAttr(input logic [HALF_W-1:0] w);
    winAttr_t a;
    a.en    = w[31];
    a.xfer  = w[10:8];
    a.width = w[7:6];
    a.sup   = w[5];
    a.pgm   = w[4];
    a.space = w[3:0];
    return a;
  endfunction
endpackage

// File: rtl/ob_window_ctrl.sv
module ob_window_ctrl
  import ob_window_pkg::*;
#(
  parameter int NUM_WIN = NUM_WIN_DEF,
  parameter int CFG_AW  = CFG_AW_DEF
) (
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [HALF_W-1:0] cfgWrData,
  input  logic              reqValid,
  output winStrobe_t        strb
);
  localparam int SLOT_W = CFG_AW - STRIDE_LG;
  localparam logic [SLOT_W-1:0] BASE_SLOT = SLOT_W'(WIN_BASE >> STRIDE_LG);
  localparam logic [SLOT_W-1:0] SLOT_CNT  = SLOT_W'(NUM_WIN);

  logic [SLOT_W-1:0] slotRel;
  logic              inMap;
  logic              aligned;

  always_comb begin
    slotRel = cfgAddr[CFG_AW-1:STRIDE_LG] - BASE_SLOT;
    inMap   = (cfgAddr[CFG_AW-1:STRIDE_LG] >= BASE_SLOT) && (slotRel < SLOT_CNT);
    aligned = (cfgAddr[1:0] == 2'b00);

    strb.wrEn    = cfgWrEn && inMap && aligned;
    strb.wrWin   = slotRel[WIN_IDX_W-1:0];
    strb.wrField = winField_e'(cfgAddr[4:2]);
    strb.wrData  = cfgWrData;
    strb.capture = reqValid;
  end
endmodule

// File: rtl/ob_window_match.sv
module ob_window_match
  import ob_window_pkg::*;
(
  input  logic              enable,
  input  logic [GRAN_W-1:0] reqGran,
  input  logic [GRAN_W-1:0] loGran,
  input  logic [GRAN_W-1:0] hiGran,
  output logic              hit
);
  logic aboveLo;
  logic belowHi;

  always_comb begin
    aboveLo = (reqGran >= loGran);
    belowHi = (reqGran <= hiGran);
    hit     = enable && aboveLo && belowHi;
  end
endmodule

// File: rtl/ob_window_datapath.sv
module ob_window_datapath
  import ob_window_pkg::*;
#(
  parameter int NUM_WIN = NUM_WIN_DEF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  winStrobe_t           strb,
  input  logic [ADDR_W-1:0]    reqAddr,
  output logic                 rspValid,
  output logic                 rspHit,
  output logic [WIN_IDX_W-1:0] rspWin,
  output logic [ADDR_W-1:0]    rspAddr,
  output logic [3:0]           rspAddrMode,
  output logic [2:0]           rspXferMode,
  output logic [1:0]           rspWidth,
  output logic                 rspSuper,
  output logic                 rspProgram
);
  logic [GRAN_W-1:0] loGran  [NUM_WIN];
  logic [GRAN_W-1:0] hiGran  [NUM_WIN];
  logic [GRAN_W-1:0] offGran [NUM_WIN];
  winAttr_t          attrQ   [NUM_WIN];
  logic [NUM_WIN-1:0] winHit;

  logic [GRAN_W-1:0] reqGran;
  assign reqGran = reqAddr[ADDR_W-1:GRAN_LG];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic selThis;
    assign selThis = strb.wrEn && (strb.wrWin == WIN_IDX_W'(w));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        loGran[w]  <= '0;
        hiGran[w]  <= '0;
        offGran[w] <= '0;
        attrQ[w]   <= '0;
      end else if (selThis) begin
        case (strb.wrField)
          FLD_LO_HI:  loGran[w][GRAN_W-1:HALF_W-GRAN_LG]  <= strb.wrData;
          FLD_LO_LO:  loGran[w][HALF_W-GRAN_LG-1:0]       <= strb.wrData[HALF_W-1:GRAN_LG];
          FLD_HI_HI:  hiGran[w][GRAN_W-1:HALF_W-GRAN_LG]  <= strb.wrData;
          FLD_HI_LO:  hiGran[w][HALF_W-GRAN_LG-1:0]       <= strb.wrData[HALF_W-1:GRAN_LG];
          FLD_OFF_HI: offGran[w][GRAN_W-1:HALF_W-GRAN_LG] <= strb.wrData;
          FLD_OFF_LO: offGran[w][HALF_W-GRAN_LG-1:0]      <= strb.wrData[HALF_W-1:GRAN_LG];
          FLD_ATTR:   attrQ[w]                            <= unpackAttr(strb.wrData);
          default:    ;
        endcase
      end
    end

    ob_window_match u_match (
      .enable (attrQ[w].en),
      .reqGran(reqGran),
      .loGran (loGran[w]),
      .hiGran (hiGran[w]),
      .hit    (winHit[w])
    );
  end

  logic                 selHit;
  logic [WIN_IDX_W-1:0] selIdx;
  logic [GRAN_W-1:0]    selOff;
  winAttr_t             selAttr;

  always_comb begin
    selHit = 1'b0;
    selIdx = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (winHit[w]) begin
        selHit = 1'b1;
        selIdx = w[WIN_IDX_W-1:0];
      end
    end
    selOff  = offGran[selIdx];
    selAttr = attrQ[selIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspWin      <= '0;
      rspAddr     <= '0;
      rspAddrMode <= '0;
      rspXferMode <= '0;
      rspWidth    <= '0;
      rspSuper    <= 1'b0;
      rspProgram  <= 1'b0;
    end else begin
      rspValid <= strb.capture;
      if (strb.capture) begin
        rspHit <= selHit;
        if (selHit) begin
          rspWin      <= selIdx;
          rspAddr     <= reqAddr + {selOff, {GRAN_LG{1'b0}}};
          rspAddrMode <= selAttr.space;
          rspXferMode <= selAttr.xfer;
          rspWidth    <= selAttr.width;
          rspSuper    <= selAttr.sup;
          rspProgram  <= selAttr.pgm;
        end else begin
          rspWin      <= '0;
          rspAddr     <= '0;
          rspAddrMode <= '0;
          rspXferMode <= '0;
          rspWidth    <= '0;
          rspSuper    <= 1'b0;
          rspProgram  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ob_window_unit.sv
module ob_window_unit
  import ob_window_pkg::*;
#(
  parameter int NUM_WIN = NUM_WIN_DEF,
  parameter int CFG_AW  = CFG_AW_DEF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [CFG_AW-1:0]    cfgAddr,
  input  logic [HALF_W-1:0]    cfgWrData,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqAddr,
  output logic                 rspValid,
  output logic                 rspHit,
  output logic [WIN_IDX_W-1:0] rspWin,
  output logic [ADDR_W-1:0]    rspAddr,
  output logic [3:0]           rspAddrMode,
  output logic [2:0]           rspXferMode,
  output logic [1:0]           rspWidth,
  output logic                 rspSuper,
  output logic                 rspProgram
);
  winStrobe_t strb;

  ob_window_ctrl #(.NUM_WIN(NUM_WIN), .CFG_AW(CFG_AW)) u_ctrl (
    .cfgWrEn  (cfgWrEn),
    .cfgAddr  (cfgAddr),
    .cfgWrData(cfgWrData),
    .reqValid (reqValid),
    .strb     (strb)
  );

  ob_window_datapath #(.NUM_WIN(NUM_WIN)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqAddr    (reqAddr),
    .rspValid   (rspValid),
    .rspHit     (rspHit),
    .rspWin     (rspWin),
    .rspAddr    (rspAddr),
    .rspAddrMode(rspAddrMode),
    .rspXferMode(rspXferMode),
    .rspWidth   (rspWidth),
    .rspSuper   (rspSuper),
    .rspProgram (rspProgram)
  );
endmodule

// File: rtl/ob_window_chk.sv
module ob_window_chk
  import ob_window_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic [ADDR_W-1:0]    reqAddr,
  input logic                 rspValid,
  input logic                 rspHit,
  input logic [WIN_IDX_W-1:0] rspWin,
  input logic [ADDR_W-1:0]    rspAddr,
  input logic [3:0]           rspAddrMode,
  input logic [2:0]           rspXferMode,
  input logic [1:0]           rspWidth,
  input logic                 rspSuper,
  input logic                 rspProgram
);
  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R9
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspAddr == '0 && rspWin == '0 && rspAddrMode == '0 &&
                               rspXferMode == '0 && rspWidth == '0 && !rspSuper && !rspProgram));

  // R5
  low_bits_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |-> (rspAddr[GRAN_LG-1:0] == $past(reqAddr[GRAN_LG-1:0])));
endmodule

bind ob_window_unit ob_window_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqAddr    (reqAddr),
  .rspValid   (rspValid),
  .rspHit     (rspHit),
  .rspWin     (rspWin),
  .rspAddr    (rspAddr),
  .rspAddrMode(rspAddrMode),
  .rspXferMode(rspXferMode),
  .rspWidth   (rspWidth),
  .rspSuper   (rspSuper),
  .rspProgram (rspProgram)
);

// File: tb/ob_window_unit_bench.sv
module ob_window_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [11:0] cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic [63:0] reqAddr = '0;
  logic        rspValid, rspHit, rspSuper, rspProgram;
  logic [2:0]  rspWin, rspXferMode;
  logic [63:0] rspAddr;
  logic [3:0]  rspAddrMode;
  logic [1:0]  rspWidth;

  always #2.5 clk = ~clk;

  ob_window_unit u_ob_window_unit (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqAddr(reqAddr), .rspValid(rspValid), .rspHit(rspHit),
    .rspWin(rspWin), .rspAddr(rspAddr), .rspAddrMode(rspAddrMode), .rspXferMode(rspXferMode),
    .rspWidth(rspWidth), .rspSuper(rspSuper), .rspProgram(rspProgram)
  );

  typedef struct {
    logic        hit;
    logic [2:0]  win;
    logic [63:0] addr;
    logic [3:0]  am;
    logic [2:0]  tm;
    logic [1:0]  dw;
    logic        sup;
    logic        pgm;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int compared = 0;
  int mismatched = 0;

  logic [63:0] mLo  [8];
  logic [63:0] mHi  [8];
  logic [63:0] mOff [8];
  logic [31:0] mAttr[8];

  // Shadow register model built from R2
  task automatic modelWrite(input logic [11:0] a, input logic [31:0] d);
    int w;
    if (a < 12'h100 || a > 12'h1FF || a[1:0] != 2'b00) return;
    w = (a - 12'h100) >> 5;
    case (a[4:2])
      3'd0: mLo[w][63:32]  = d;
      3'd1: mLo[w][31:0]   = d;
      3'd2: mHi[w][63:32]  = d;
      3'd3: mHi[w][31:0]   = d;
      3'd4: mOff[w][63:32] = d;
      3'd5: mOff[w][31:0]  = d;
      3'd7: mAttr[w]       = d;
      default: ;
    endcase
  endtask

  function automatic expItem_t predict(input logic [63:0] a, input string tag);
    expItem_t e;
    e.hit = 0; e.win = 0; e.addr = 0; e.am = 0; e.tm = 0; e.dw = 0; e.sup = 0; e.pgm = 0;
    e.tag = tag;
    for (int w = 7; w >= 0; w--) begin
      if (mAttr[w][31] && a[63:16] >= mLo[w][63:16] && a[63:16] <= mHi[w][63:16]) begin
        e.hit = 1;
        e.win = w[2:0];
        e.addr = a + {mOff[w][63:16], 16'h0};
        e.am = mAttr[w][3:0];
        e.tm = mAttr[w][10:8];
        e.dw = mAttr[w][7:6];
        e.sup = mAttr[w][5];
        e.pgm = mAttr[w][4];
      end
    end
    return e;
  endfunction

  task automatic cfgWrite(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reqValid = 1'b0;
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    modelWrite(a, d);
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
  endtask

  task automatic winSetup(input int w, input logic [63:0] lo, input logic [63:0] hi,
                          input logic [63:0] off, input logic [31:0] attr);
    logic [11:0] b;
    b = 12'(12'h100 + w * 32);
    cfgWrite(b + 12'h00, lo[63:32]);
    cfgWrite(b + 12'h04, lo[31:0]);
    cfgWrite(b + 12'h08, hi[63:32]);
    cfgWrite(b + 12'h0C, hi[31:0]);
    cfgWrite(b + 12'h10, off[63:32]);
    cfgWrite(b + 12'h14, off[31:0]);
    cfgWrite(b + 12'h1C, attr);
  endtask

  // Driver: presents a request for one cycle (callers chain for bursts)
  task automatic doReq(input logic [63:0] a, input string tag);
    @(posedge clk); #1;
    reqValid = 1'b1; reqAddr = a;
    expQ.push_back(predict(a, tag));
  endtask

  task automatic endReq();
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  // Same-edge write and request: the request sees the old state (R9)
  task automatic writeWithReq(input logic [11:0] ca, input logic [31:0] d,
                              input logic [63:0] a, input string tag);
    @(posedge clk); #1;
    expQ.push_back(predict(a, tag));
    reqValid = 1'b1; reqAddr = a;
    cfgWrEn = 1'b1; cfgAddr = ca; cfgWrData = d;
    modelWrite(ca, d);
    @(posedge clk); #1;
    reqValid = 1'b0; cfgWrEn = 1'b0;
  endtask

  // Monitor: pops and compares at the falling edge
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      compared++;
      if (expQ.size() == 0) begin
        mismatched++;
        $display("FAIL R9 unexpected response: got valid=1 expected no response");
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (rspHit !== e.hit || rspWin !== e.win || rspAddr !== e.addr ||
            rspAddrMode !== e.am || rspXferMode !== e.tm || rspWidth !== e.dw ||
            rspSuper !== e.sup || rspProgram !== e.pgm) begin
          mismatched++;
          $display("FAIL %s: got hit=%0d win=%0d addr=%h am=%h tm=%0d dw=%0d sup=%0d pgm=%0d expected hit=%0d win=%0d addr=%h am=%h tm=%0d dw=%0d sup=%0d pgm=%0d",
                   e.tag, rspHit, rspWin, rspAddr, rspAddrMode, rspXferMode, rspWidth, rspSuper, rspProgram,
                   e.hit, e.win, e.addr, e.am, e.tm, e.dw, e.sup, e.pgm);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got run still active expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int w = 0; w < 8; w++) begin
      mLo[w] = 0; mHi[w] = 0; mOff[w] = 0; mAttr[w] = 0;
    end
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    compared++;
    if (rspValid !== 1'b0 || rspHit !== 1'b0 || rspAddr !== 64'h0) begin
      mismatched++;
      $display("FAIL R1 reset: got valid=%0d hit=%0d addr=%h expected 0 0 0", rspValid, rspHit, rspAddr);
    end

    doReq(64'h0000_0000_1234_5678, "R1 miss after reset");
    endReq();

    // R3: fully programmed but disabled window
    winSetup(2, 64'h0000_0000_1000_ABCD, 64'h0000_0000_1003_1234,
             64'h0000_0001_2000_5555, 32'h0000_0162);
    doReq(64'h0000_0000_1000_0010, "R3 disabled window");
    endReq();

    cfgWrite(12'h15C, 32'h8000_0162);
    // R4 R5 R8 burst of back-to-back requests
    doReq(64'h0000_0000_1000_0012, "R4 first granule / R5 offset / R8 attrs");
    doReq(64'h0000_0000_1003_FFFF, "R4 last granule inclusive");
    doReq(64'h0000_0000_1004_0000, "R4 above end");
    doReq(64'h0000_0000_0FFF_FFFF, "R4 below start");
    endReq();

    // R2: spare slot, out-of-map and misaligned writes have no effect
    cfgWrite(12'h158, 32'hFFFF_FFFF);
    cfgWrite(12'h300, 32'h0000_0000);
    cfgWrite(12'h0FC, 32'hFFFF_FFFF);
    cfgWrite(12'h15D, 32'h0000_0000);
    doReq(64'h0000_0000_1001_0000, "R2 ignored writes");
    endReq();

    // R6 priority among overlapping windows
    winSetup(5, 64'h0000_0000_1000_0000, 64'h0000_0000_1FFF_0000,
             64'h0000_0000_4000_0000, 32'h8000_0511);
    doReq(64'h0000_0000_1500_0000, "R6 only window 5");
    doReq(64'h0000_0000_1002_0000, "R6 window 2 beats 5");
    endReq();
    winSetup(0, 64'h0000_0000_1000_0000, 64'h0000_0000_1000_FFFF,
             64'h0, 32'h8000_0008);
    doReq(64'h0000_0000_1000_8000, "R6 window 0 beats 2 and 5");
    endReq();

    // R5 R8 upper-half address with wrapping offset
    winSetup(7, 64'h0000_0001_0000_0000, 64'h0000_0001_FFFF_0000,
             64'hFFFF_FFFF_0000_0000, 32'h8000_0404);
    doReq(64'h0000_0001_8000_0042, "R5 64-bit wrap / R8 attrs");
    doReq(64'h0000_0002_0000_0000, "R7 miss above all");
    endReq();

    // R9 write at same edge as request
    writeWithReq(12'h11C, 32'h0000_0008, 64'h0000_0000_1000_8000, "R9 same-edge write unseen");
    doReq(64'h0000_0000_1000_8000, "R9 write seen next");
    endReq();

    repeat (3) @(posedge clk);
    @(negedge clk);
    compared++;
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL R9 missing responses: got %0d pending expected 0", expQ.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule